// File: doc/BRIEF.md
# Clock-Sequence Edge-Window Checker

This block judges whether one shift command, driven as a bundle of externally generated clock lines, kept to its expected timing pattern. A start indication marks the beginning of a command. From then on a local cycle counter runs, and at a set of planned sample cycles the block compares one line against the level that line must have at that moment. Each intended transition is covered by two samples. One sample falls before the nominal edge and expects the old level. The other falls after the edge and expects the new level. The block therefore accepts an edge that lands anywhere inside that window, and it uses no edge detector.

The sample plan is a parameter table of (line, cycle, level) entries in ascending cycle order. The same block serves two bundles. On a slow sampling clock it checks the vertical bundle and latches its verdict. On a fast clock it checks a horizontal bundle and gives its verdict as a short pulse, which opens the window in which a pixel value is fetched. The lines pass through a two-flop synchronizer before they are compared. The start input and the outputs are plain control pins.

Top module: `clkseq_window_checker`

## Requirements
- R1: While reset is applied, and until the first start is sampled after it, `good_o` and `done_o` are low.
- R2: Bit n of `lines_i` is line n. Each table entry names a line index, a cycle offset and a level. The default vertical table, with lines 0..4 standing for the transfer gate, phases 1..3 and the trigger line, is: (0,100,1) (0,140,0) (2,300,0) (2,340,1) (1,580,1) (1,620,0) (3,800,1) (3,840,0) (1,1188,0) (1,1236,1) (4,1300,0) (4,1320,1).
- R3: When `start_i` is high at clock edge k, an entry with cycle C is judged at edge k+1+C. It passes only if the synchronized line equals the entry's level there. The synchronized line is the input as sampled two edges earlier.
- R4: `done_o` is high for exactly one cycle, and it rises at edge k+1+L, where L is the cycle of the last entry. This holds whether the sequence passed or failed.
- R5: If any single entry fails, the verdict of the whole sequence is fail. `done_o` still fires.
- R6: In hold mode (PULSE_LEN = 0), `good_o` rises in the same cycle as `done_o` when every entry passed, and it stays high until the next start. A start clears `good_o` at the edge that samples it. `good_o` changes at no other time.
- R7: In pulse mode (PULSE_LEN > 0), a passing sequence drives `good_o` high for exactly PULSE_LEN cycles, starting in the `done_o` cycle. A failing sequence leaves it low.
- R8: A start sampled while a sequence is running abandons that sequence. No `done_o` is given for the abandoned sequence, and timing restarts from the new start.
- R9: While no sequence is running, activity on `lines_i` produces no `done_o` and does not change `good_o`.
- R10: If a start is sampled at the same edge as the last entry of the running sequence, the start wins. No `done_o` or verdict is produced for the old sequence, and the new one is timed from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of a command sequence, synchronous, one cycle |
| lines_i | input | NLINES | Clock lines under test, asynchronous |
| good_o | output | 1 | Verdict: latched (hold mode) or pulsed (pulse mode) |
| done_o | output | 1 | One-cycle strobe after the last sample point |

## Verification
The start of a new command and the judgement of the last sample point of the running one can land on the same clock edge. The bench provokes this by raising `start_i` so that it is sampled at exactly edge k+1+L of the current run. This is done on both the latching and the pulsing instance. It then requires that no `done_o` and no verdict appear in the following cycle, and that the new run's strobe arrives L+1 cycles after the second start. A start sampled in the middle of a run is handled the same way, and is judged by when the strobe arrives and by how many strobes appear.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam int unsigned LINE_W = 3;
  localparam int unsigned CYC_W  = 16;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [CYC_W-1:0]  cyc;
    logic              lvl;
  } point_t;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  localparam int unsigned VERT_NPTS = 12;
  localparam point_t [0:VERT_NPTS-1] VERT_TABLE = '{
    '{3'd0, 16'd100,  1'b1}, '{3'd0, 16'd140,  1'b0},
    '{3'd2, 16'd300,  1'b0}, '{3'd2, 16'd340,  1'b1},
    '{3'd1, 16'd580,  1'b1}, '{3'd1, 16'd620,  1'b0},
    '{3'd3, 16'd800,  1'b1}, '{3'd3, 16'd840,  1'b0},
    '{3'd1, 16'd1188, 1'b0}, '{3'd1, 16'd1236, 1'b1},
    '{3'd4, 16'd1300, 1'b0}, '{3'd4, 16'd1320, 1'b1}
  };

  localparam int unsigned HORZ_NPTS = 6;
  localparam point_t [0:HORZ_NPTS-1] HORZ_TABLE = '{
    '{3'd0, 16'd4,  1'b1}, '{3'd0, 16'd8,  1'b0},
    '{3'd1, 16'd12, 1'b0}, '{3'd1, 16'd16, 1'b1},
    '{3'd4, 16'd20, 1'b1}, '{3'd4, 16'd24, 1'b0}
  };
endpackage

// File: rtl/clkseq_line_sync.sv
module clkseq_line_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/clkseq_window_seq.sv
module clkseq_window_seq
  import clkseq_pkg::*;
#(
  parameter int unsigned NLINES = 5,
  parameter int unsigned NPTS   = VERT_NPTS,
  parameter point_t [0:NPTS-1] TABLE = VERT_TABLE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NLINES-1:0] line_i,
  output logic              fin_o,
  output logic              pass_o,
  output logic              done_o
);
  localparam int unsigned IW = (NPTS > 1) ? $clog2(NPTS) : 1;

  seq_state_e       state;
  logic [CYC_W-1:0] cnt;
  logic [IW-1:0]    idx;
  logic             fail;
  point_t           cur;
  logic             sample, hit, miss, last;

  assign cur    = TABLE[idx];
  assign sample = line_i[cur.line];
  assign hit    = (state == ST_RUN) && (cnt == cur.cyc);
  assign miss   = (sample != cur.lvl);
  assign last   = (idx == IW'(NPTS - 1));
  assign fin_o  = hit && last && !start_i;
  assign pass_o = !(fail || miss);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      fail   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= fin_o;
      if (start_i) begin
        state <= ST_RUN;
        cnt   <= '0;
        idx   <= '0;
        fail  <= 1'b0;
      end else if (state == ST_RUN) begin
        cnt <= cnt + CYC_W'(1);
        if (hit) begin
          if (last) begin
            state <= ST_IDLE;
          end else begin
            idx  <= idx + IW'(1);
            fail <= fail || miss;
          end
        end
      end
    end
  end
endmodule

// File: rtl/clkseq_verdict.sv
module clkseq_verdict #(
  parameter int unsigned PULSE_LEN = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic fin_i,
  input  logic pass_i,
  output logic good_o
);
  if (PULSE_LEN == 0) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      good_o <= 1'b0;
      else if (clear_i) good_o <= 1'b0;
      else if (fin_i)   good_o <= pass_i;
    end
  end else begin : g_pulse
    localparam int unsigned PW = $clog2(PULSE_LEN + 1);
    logic [PW-1:0] left;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               left <= '0;
      else if (clear_i)          left <= '0;
      else if (fin_i && pass_i)  left <= PW'(PULSE_LEN);
      else if (left != '0)       left <= left - PW'(1);
    end
    assign good_o = (left != '0);
  end
endmodule

// File: rtl/clkseq_window_checker.sv
module clkseq_window_checker
  import clkseq_pkg::*;
#(
  parameter int unsigned NLINES    = 5,
  parameter int unsigned NPTS      = VERT_NPTS,
  parameter point_t [0:NPTS-1] TABLE = VERT_TABLE,
  parameter int unsigned SYNC_STG  = 2,
  parameter int unsigned PULSE_LEN = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NLINES-1:0] lines_i,
  output logic              good_o,
  output logic              done_o
);
  localparam int unsigned LAST_CYC = int'(TABLE[NPTS-1].cyc);

  logic [NLINES-1:0] lines_s;
  logic              fin, pass;

  clkseq_line_sync #(.WIDTH(NLINES), .STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(lines_i), .sync_o(lines_s)
  );

  clkseq_window_seq #(.NLINES(NLINES), .NPTS(NPTS), .TABLE(TABLE)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .line_i(lines_s),
    .fin_o(fin), .pass_o(pass), .done_o(done_o)
  );

  clkseq_verdict #(.PULSE_LEN(PULSE_LEN)) u_verdict (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_i),
    .fin_i(fin), .pass_i(pass), .good_o(good_o)
  );
endmodule

// File: rtl/clkseq_window_props.sv
module clkseq_window_props #(
  parameter int unsigned PULSE_LEN = 0,
  parameter int unsigned LAST_CYC  = 1,
  parameter int unsigned CW        = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic good_o,
  input logic done_o
);
  logic          armed;
  logic [CW:0]   since;
  logic [CW:0]   hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed <= 1'b0;
      since <= '0;
    end else if (start_i) begin
      armed <= 1'b1;
      since <= '0;
    end else if (done_o) begin
      armed <= 1'b0;
    end else if (armed && since != '1) begin
      since <= since + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hi_run <= '0;
    else if (!good_o)             hi_run <= '0;
    else if (hi_run != '1)        hi_run <= hi_run + 1'b1;
  end

  // R4: strobe lasts one cycle
  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4, R8, R10: strobe only at the planned distance from the latest start
  p_done_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (armed && since == (CW+1)'(LAST_CYC + 1)));

  // R6, R7: a verdict only appears together with the strobe
  p_good_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(good_o) |-> done_o);

  // R6, R10: a start clears verdict and strobe
  p_start_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!good_o && !done_o));

  if (PULSE_LEN == 0) begin : g_hold_chk
    // R6, R9: latched verdict moves only at a strobe or after a start
    p_hold_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(good_o) |-> (done_o || $past(start_i)));
  end else begin : g_pulse_chk
    // R7: pulse never exceeds its length
    p_pulse_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      good_o |-> (hi_run < (CW+1)'(PULSE_LEN)));
  end
endmodule

bind clkseq_window_checker clkseq_window_props #(
  .PULSE_LEN(PULSE_LEN), .LAST_CYC(LAST_CYC), .CW(clkseq_pkg::CYC_W)
) u_props (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .good_o(good_o), .done_o(done_o)
);

// File: tb/test_clkseq_window_checker.sv
module test_clkseq_window_checker;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       start_v, start_h;
  logic [4:0] lines_v, lines_h;
  logic       good_v, done_v, good_h, done_h;

  clkseq_window_checker i_clkseq_window_checker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_v), .lines_i(lines_v),
    .good_o(good_v), .done_o(done_v)
  );

  clkseq_window_checker #(
    .NPTS(clkseq_pkg::HORZ_NPTS), .TABLE(clkseq_pkg::HORZ_TABLE), .PULSE_LEN(2)
  ) i_clkseq_window_checker_h (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_h), .lines_i(lines_h),
    .good_o(good_h), .done_o(done_h)
  );

  int n_chk = 0, n_err = 0;
  int tl[2][12], tc[2][12], tv[2][12];
  int np[2];

  task automatic set_pt(int h, int i, int ln, int cy, int lv);
    tl[h][i] = ln; tc[h][i] = cy; tv[h][i] = lv;
  endtask

  task automatic load_tables();
    // R2 vertical plan
    set_pt(0,0,0,100,1);  set_pt(0,1,0,140,0);  set_pt(0,2,2,300,0);
    set_pt(0,3,2,340,1);  set_pt(0,4,1,580,1);  set_pt(0,5,1,620,0);
    set_pt(0,6,3,800,1);  set_pt(0,7,3,840,0);  set_pt(0,8,1,1188,0);
    set_pt(0,9,1,1236,1); set_pt(0,10,4,1300,0); set_pt(0,11,4,1320,1);
    np[0] = 12;
    set_pt(1,0,0,4,1);  set_pt(1,1,0,8,0);  set_pt(1,2,1,12,0);
    set_pt(1,3,1,16,1); set_pt(1,4,4,20,1); set_pt(1,5,4,24,0);
    np[1] = 6;
  endtask

  function automatic int nominal(int h, int ln, int c);
    int bd = 1 << 30;
    int lv = 0;
    for (int p = 0; p < np[h]; p++) begin
      if (tl[h][p] == ln) begin
        int d = (c > tc[h][p]) ? c - tc[h][p] : tc[h][p] - c;
        if (d < bd) begin bd = d; lv = tv[h][p]; end
      end
    end
    return lv;
  endfunction

  function automatic logic [4:0] wave(int h, int rel, int bad);
    logic [4:0] w;
    for (int ln = 0; ln < 5; ln++) begin
      w[ln] = nominal(h, ln, rel) != 0;
      if (bad >= 0 && ln == tl[h][bad] &&
          rel >= tc[h][bad] - 4 && rel <= tc[h][bad] + 4)
        w[ln] = ~w[ln];
    end
    return w;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int h, logic st, logic [4:0] ln);
    if (h != 0) begin start_h = st; lines_h = ln; end
    else        begin start_v = st; lines_v = ln; end
  endtask

  function automatic logic obs_done(int h);
    return (h != 0) ? done_h : done_v;
  endfunction

  function automatic logic obs_good(int h);
    return (h != 0) ? good_h : good_v;
  endfunction

  // one command; optional corrupted point and optional second start
  task automatic run_seq(int h, int bad, int restart_at, string req);
    int L = tc[h][np[h]-1];
    int off = 0;
    int dexp = L + 1;
    int pexp = (bad < 0) ? 1 : 0;
    @(negedge clk);
    drive(h, 1'b1, wave(h, 0, bad));
    for (int c = 0; c <= dexp + 3; c++) begin
      @(negedge clk);
      if (c == dexp)
        check(obs_done(h) == 1'b1, (bad < 0) ? "R4 done timing" : "R4 R5 done on fail",
              obs_done(h), 1);
      else if (obs_done(h))
        check(1'b0, "R4 R8 unexpected done", c, dexp);
      if (c == 0 && restart_at < 0)
        check(obs_good(h) == 1'b0, "R6 start clears verdict", obs_good(h), 0);
      if (restart_at >= 0 && c == restart_at + 1)
        check(obs_good(h) == 1'b0 && obs_done(h) == 1'b0,
              (restart_at == L) ? "R10 start beats last sample" : "R8 abandoned run",
              {obs_good(h), obs_done(h)}, 0);
      if (c == dexp - 1)
        check(obs_good(h) == 1'b0, "R6 R7 no early verdict", obs_good(h), 0);
      if (c == dexp || c == dexp + 1)
        check(obs_good(h) == pexp[0], req, obs_good(h), pexp);
      if (c == dexp + 2)
        check(obs_good(h) == ((h != 0) ? 1'b0 : pexp[0]),
              (h != 0) ? "R7 pulse length" : "R6 verdict held", obs_good(h),
              (h != 0) ? 0 : pexp);
      if (c == restart_at) begin
        off = c + 1;
        dexp = off + L + 1;
        drive(h, 1'b1, wave(h, 0, bad));
      end else begin
        drive(h, 1'b0, wave(h, c + 1 - off, bad));
      end
    end
  endtask

  task automatic idle_toggle(int h, int n);
    logic g0 = obs_good(h);
    int bad_evt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive(h, 1'b0, 5'($urandom));
      if (obs_done(h) || obs_good(h) != g0) bad_evt++;
    end
    check(bad_evt == 0, "R9 idle lines ignored", bad_evt, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    load_tables();
    rst_n = 1'b0;
    drive(0, 1'b0, 5'd0);
    drive(1, 1'b0, 5'd0);
    repeat (4) @(negedge clk);
    check(good_v == 0 && done_v == 0, "R1 reset vertical", {good_v, done_v}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(good_h == 0 && done_h == 0, "R1 reset horizontal", {good_h, done_h}, 0);

    run_seq(0, -1, -1, "R2 R6 clean vertical pass");
    idle_toggle(0, 60);
    run_seq(0, 5, -1, "R3 R5 corrupted V1 falling edge");
    run_seq(0, 11, -1, "R3 R5 corrupted last point");
    for (int t = 0; t < 5; t++) begin
      int b = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, 11));
      run_seq(0, b, -1, (b < 0) ? "R6 random pass" : "R3 R5 random fail");
    end
    run_seq(0, -1, 700, "R8 R6 restart mid run");
    run_seq(0, -1, 1320, "R10 R6 start on last sample");

    run_seq(1, -1, -1, "R2 R7 clean horizontal pulse");
    idle_toggle(1, 40);
    run_seq(1, 0, -1, "R3 R7 corrupted first point");
    for (int t = 0; t < 20; t++) begin
      int b = ($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(0, 5));
      run_seq(1, b, -1, (b < 0) ? "R7 random pass" : "R3 R5 random fail");
    end
    run_seq(1, -1, 10, "R8 R7 restart mid run");
    run_seq(1, -1, 24, "R10 R7 start on last sample");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule